// File: doc/BRIEF.md
# Modulo up/down timer counter

This block is a free-running 16-bit timer counter with a programmable terminal count. It advances once for each cycle on which the timer-clock enable is high and the freeze input is low. A mode input selects plain up counting, which wraps at the terminal count, or symmetric up/down counting, which turns around at the terminal count and at zero. An overflow flag marks the turning point in each mode. A one-cycle overflow pulse also reports each such event.

Software reaches the block through a byte-wide register bus. It can set the modulus one byte at a time, read the count, restart the count by writing to it, and clear the overflow flag by writing a one to it. Reads of the two count bytes are kept coherent. Whichever byte is read first causes the other byte to be captured, so a two-byte read in either order returns one consistent value.

Top module: `modtmr_core`

## Requirements
- R1: After reset the count is 0x0000, the overflow flag and pulse are 0, both modulus bytes read 0x00, and the counting direction is upward.
- R2: The count changes only on a clock edge where `tick_en` is 1 and `freeze` is 0. With `tick_en` low or `freeze` high it holds its value.
- R3: The terminal count equals the modulus when the modulus is non-zero, and 0xFFFF when the modulus is zero.
- R4: With `center_mode` = 0, the count steps up by one from 0x0000 to the terminal count. The next step returns it to 0x0000, and that same step sets the overflow flag.
- R5: With `center_mode` = 1, the count rises from 0x0000 to the terminal count, falls back to 0x0000 and rises again. Each turning value is held for exactly one step, with no repeated count.
- R6: With `center_mode` = 1, the overflow flag sets on the step that moves the count from the terminal count to the terminal count minus one. It does not set at the zero turning point.
- R7: A bus write of any data to address 0 (count high byte) or address 1 (count low byte) sets the count to 0x0000 and restarts it upward. A simultaneous tick is overridden.
- R8: A read of one count byte returns that byte's live value and captures the other byte. The next read of the other byte returns the captured value and releases the capture. Address 0 is the high byte and address 1 is the low byte.
- R9: A write to either count byte abandons a pending capture, so the following read of either byte returns its live value.
- R10: Address 4 is the status register, and the overflow flag reads in bit 7. A write to address 4 with bit 7 = 1 clears the flag, and a write with bit 7 = 0 leaves it unchanged. A new overflow in the same cycle as the clear wins.
- R11: `ovf_pulse` is 1 for exactly the one cycle that follows the clock edge on which an overflow sets the flag.
- R12: Address 2 holds the modulus high byte and address 3 the modulus low byte. Each byte is written independently and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer-clock enable; one count step per high cycle |
| freeze | input | 1 | Holds the count while high |
| center_mode | input | 1 | 0 = up counting, 1 = up/down counting |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-cycle overflow event |

## Verification
Read data is combinational from the address and the capture state. The bench therefore samples `bus_rdata` during the read cycle itself, before the edge that updates the capture. Count, flag and modulus updates from a tick or a write appear one edge after the strobe, so every check waits for the following falling edge. `ovf_pulse` is checked at the falling edge right after the wrapping tick and again one cycle later, to prove it lasts a single cycle. The directed tests drive each count to a known value with an exact number of enabled edges before reading it.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  localparam int A_CNT_HI = 0;
  localparam int A_CNT_LO = 1;
  localparam int A_MOD_HI = 2;
  localparam int A_MOD_LO = 3;
  localparam int A_STAT   = 4;

  typedef enum logic [1:0] {
    SNAP_NONE    = 2'd0,
    SNAP_HOLD_HI = 2'd1,
    SNAP_HOLD_LO = 2'd2
  } snap_st_e;
endpackage

// File: rtl/modtmr_count.sv
module modtmr_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         center,
  input  logic         clr,
  input  logic [W-1:0] term,
  output logic [W-1:0] cnt,
  output logic         hit
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    hit   = 1'b0;
    if (clr) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else begin
      if (!center) up_d = 1'b1;
      if (adv) begin
        if (!center) begin
          if (cnt_q == term) begin
            cnt_d = '0;
            hit   = 1'b1;
          end else begin
            cnt_d = cnt_q + W'(1);
          end
        end else if (cnt_q == term) begin
          cnt_d = cnt_q - W'(1);
          up_d  = 1'b0;
          hit   = 1'b1;
        end else if (cnt_q == '0) begin
          cnt_d = W'(1);
          up_d  = 1'b1;
        end else if (up_q) begin
          cnt_d = cnt_q + W'(1);
        end else begin
          cnt_d = cnt_q - W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/modtmr_snap.sv
module modtmr_snap
  import modtmr_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_hi,
  input  logic          rd_lo,
  input  logic          clr,
  input  logic [2*BW-1:0] cnt,
  output logic [BW-1:0] hi_byte,
  output logic [BW-1:0] lo_byte
);
  snap_st_e      st_q, st_d;
  logic [BW-1:0] buf_q, buf_d;

  always_comb begin
    st_d  = st_q;
    buf_d = buf_q;
    if (clr) begin
      st_d = SNAP_NONE;
    end else if (rd_hi) begin
      if (st_q == SNAP_HOLD_HI) begin
        st_d = SNAP_NONE;
      end else begin
        st_d  = SNAP_HOLD_LO;
        buf_d = cnt[BW-1:0];
      end
    end else if (rd_lo) begin
      if (st_q == SNAP_HOLD_LO) begin
        st_d = SNAP_NONE;
      end else begin
        st_d  = SNAP_HOLD_HI;
        buf_d = cnt[2*BW-1:BW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SNAP_NONE;
      buf_q <= '0;
    end else begin
      st_q  <= st_d;
      buf_q <= buf_d;
    end
  end

  assign hi_byte = (st_q == SNAP_HOLD_HI) ? buf_q : cnt[2*BW-1:BW];
  assign lo_byte = (st_q == SNAP_HOLD_LO) ? buf_q : cnt[BW-1:0];
endmodule

// File: rtl/modtmr_core.sv
module modtmr_core
  import modtmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              freeze,
  input  logic              center_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              ovf_flag,
  output logic              ovf_pulse
);
  localparam int CNT_W = 2 * BYTE_W;

  logic              sel_cnt_hi, sel_cnt_lo, sel_mod_hi, sel_mod_lo, sel_stat;
  logic              cnt_wr, adv, ovf_hit;
  logic [CNT_W-1:0]  cnt_q, term_w;
  logic [BYTE_W-1:0] mod_hi_q, mod_hi_d, mod_lo_q, mod_lo_d;
  logic [BYTE_W-1:0] cnt_hi_b, cnt_lo_b;
  logic              flag_q, flag_d, pulse_q, pulse_d;

  assign sel_cnt_hi = (bus_addr == ADDR_W'(A_CNT_HI));
  assign sel_cnt_lo = (bus_addr == ADDR_W'(A_CNT_LO));
  assign sel_mod_hi = (bus_addr == ADDR_W'(A_MOD_HI));
  assign sel_mod_lo = (bus_addr == ADDR_W'(A_MOD_LO));
  assign sel_stat   = (bus_addr == ADDR_W'(A_STAT));

  assign cnt_wr = bus_wr && (sel_cnt_hi || sel_cnt_lo);
  assign adv    = tick_en && !freeze;
  assign term_w = ({mod_hi_q, mod_lo_q} == '0) ? {CNT_W{1'b1}} : {mod_hi_q, mod_lo_q};

  modtmr_count #(.W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .center (center_mode),
    .clr    (cnt_wr),
    .term   (term_w),
    .cnt    (cnt_q),
    .hit    (ovf_hit)
  );

  modtmr_snap #(.BW(BYTE_W)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_hi   (bus_rd && sel_cnt_hi),
    .rd_lo   (bus_rd && sel_cnt_lo),
    .clr     (cnt_wr),
    .cnt     (cnt_q),
    .hi_byte (cnt_hi_b),
    .lo_byte (cnt_lo_b)
  );

  always_comb begin
    mod_hi_d = mod_hi_q;
    mod_lo_d = mod_lo_q;
    if (bus_wr && sel_mod_hi) mod_hi_d = bus_wdata;
    if (bus_wr && sel_mod_lo) mod_lo_d = bus_wdata;
    flag_d = flag_q;
    if (bus_wr && sel_stat && bus_wdata[BYTE_W-1]) flag_d = 1'b0;
    if (ovf_hit) flag_d = 1'b1;
    pulse_d = ovf_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_hi_q <= '0;
      mod_lo_q <= '0;
      flag_q   <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      mod_hi_q <= mod_hi_d;
      mod_lo_q <= mod_lo_d;
      flag_q   <= flag_d;
      pulse_q  <= pulse_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_cnt_hi)      bus_rdata = cnt_hi_b;
    else if (sel_cnt_lo) bus_rdata = cnt_lo_b;
    else if (sel_mod_hi) bus_rdata = mod_hi_q;
    else if (sel_mod_lo) bus_rdata = mod_lo_q;
    else if (sel_stat)   bus_rdata = {flag_q, {(BYTE_W-1){1'b0}}};
  end

  assign ovf_flag  = flag_q;
  assign ovf_pulse = pulse_q;
endmodule

// File: rtl/modtmr_core_chk.sv
module modtmr_core_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              freeze,
  input logic              center_mode,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  term,
  input logic              ovf_flag,
  input logic              ovf_pulse
);
  logic cw, go;
  assign cw = bus_wr && (bus_addr < ADDR_W'(2));
  assign go = tick_en && !freeze;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !cw) |=> $stable(cnt));

  a_r4_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!center_mode && go && !cw && cnt == term) |=> (cnt == '0 && ovf_flag));

  a_r5_zero_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (center_mode && go && !cw && cnt == '0) |=> (cnt == CNT_W'(1)));

  a_r6_top_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (center_mode && go && !cw && cnt == term) |=> (cnt == $past(term) - CNT_W'(1) && ovf_flag));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> (cnt == '0));

  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ovf_flag);
endmodule

bind modtmr_core modtmr_core_chk #(.CNT_W(2*BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .freeze      (freeze),
  .center_mode (center_mode),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .cnt         (cnt_q),
  .term        (term_w),
  .ovf_flag    (ovf_flag),
  .ovf_pulse   (ovf_pulse)
);

// File: tb/modtmr_core_tb.sv
`timescale 1ns/1ps
module modtmr_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, freeze = 1'b0, center_mode = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ovf_flag, ovf_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  modtmr_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
    .center_mode(center_mode), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );

  // fields: center(1) mod(16) ticks(16) expected count(16) expected flag(1)
  localparam int NV = 11;
  localparam logic [49:0] VEC [0:NV-1] = '{
    {1'b0, 16'd5, 16'd3,  16'd3,  1'b0},  // R4 below terminal
    {1'b0, 16'd5, 16'd5,  16'd5,  1'b0},  // R4 at terminal
    {1'b0, 16'd5, 16'd6,  16'd0,  1'b1},  // R4 wrap
    {1'b0, 16'd5, 16'd8,  16'd2,  1'b1},  // R4 after wrap
    {1'b0, 16'd0, 16'd10, 16'd10, 1'b0},  // R3 zero modulus
    {1'b1, 16'd4, 16'd3,  16'd3,  1'b0},  // R5 rising
    {1'b1, 16'd4, 16'd4,  16'd4,  1'b0},  // R5 at terminal
    {1'b1, 16'd4, 16'd5,  16'd3,  1'b1},  // R6 leaving terminal
    {1'b1, 16'd4, 16'd8,  16'd0,  1'b1},  // R5 at zero
    {1'b1, 16'd4, 16'd9,  16'd1,  1'b1},  // R5 rising again
    {1'b1, 16'd1, 16'd3,  16'd1,  1'b1}   // R5 minimal span
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] h, l;
    br(3'd0, h);
    br(3'd1, l);
    v = {h, l};
  endtask

  task automatic tick(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic setup(input logic c, input logic [15:0] m);
    center_mode = c;
    bw(3'd3, m[7:0]);
    bw(3'd2, m[15:8]);
    bw(3'd0, 8'h00);
    bw(3'd4, 8'h80);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL all: watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_cnt(v);       chk("R1 count", v, 16'h0000);
    br(3'd4, b);     chk("R1 status", {8'h0, b}, 16'h0000);
    br(3'd2, b);     chk("R1 mod hi", {8'h0, b}, 16'h0000);
    br(3'd3, b);     chk("R1 mod lo", {8'h0, b}, 16'h0000);
    chk("R1 pulse", {15'h0, ovf_pulse}, 16'h0000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic        c, f;
      logic [15:0] m, n, e;
      {c, m, n, e, f} = VEC[i];
      setup(c, m);
      tick(int'(n));
      rd_cnt(v);
      chk($sformatf("R5/R4 vec%0d count", i), v, e);
      br(3'd4, b);
      chk($sformatf("R6/R4 vec%0d flag", i), {15'h0, b[7]}, {15'h0, f});
    end

    // R12 modulus bytes independent
    bw(3'd2, 8'hC3); bw(3'd3, 8'h3C);
    br(3'd2, b); chk("R12 mod hi", {8'h0, b}, 16'h00C3);
    br(3'd3, b); chk("R12 mod lo", {8'h0, b}, 16'h003C);

    // R2 hold without enable or under freeze
    setup(1'b0, 16'h0000);
    repeat (4) @(negedge clk);
    rd_cnt(v); chk("R2 no enable", v, 16'h0000);
    @(negedge clk); freeze = 1'b1; tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0; freeze = 1'b0;
    rd_cnt(v); chk("R2 frozen", v, 16'h0000);
    tick(4);
    rd_cnt(v); chk("R2 advance", v, 16'h0004);

    // R7 writes to either byte restart
    bw(3'd1, 8'h5A);
    rd_cnt(v); chk("R7 low write", v, 16'h0000);
    tick(3);
    bw(3'd0, 8'hA5);
    rd_cnt(v); chk("R7 high write", v, 16'h0000);

    // R8 coherent read, low first
    tick(255);
    br(3'd1, b); chk("R8 live low", {8'h0, b}, 16'h00FF);
    tick(1);
    br(3'd0, b); chk("R8 captured high", {8'h0, b}, 16'h0000);
    rd_cnt(v);   chk("R8 fresh read", v, 16'h0100);

    // R9 write abandons pending capture
    br(3'd1, b); chk("R9 low", {8'h0, b}, 16'h0000);
    bw(3'd1, 8'h00);
    br(3'd0, b); chk("R9 high live", {8'h0, b}, 16'h0000);
    br(3'd1, b); chk("R9 low live", {8'h0, b}, 16'h0000);

    // R3 zero modulus wraps at 0xFFFF
    setup(1'b0, 16'h0000);
    tick(65535);
    rd_cnt(v); chk("R3 full count", v, 16'hFFFF);
    chk("R3 no flag yet", {15'h0, ovf_flag}, 16'h0000);
    tick(1);
    rd_cnt(v); chk("R3 wrap", v, 16'h0000);
    chk("R3 flag", {15'h0, ovf_flag}, 16'h0001);

    // R10 write-one-to-clear
    bw(3'd4, 8'h7F);
    br(3'd4, b); chk("R10 zero write keeps", {15'h0, b[7]}, 16'h0001);
    bw(3'd4, 8'h80);
    br(3'd4, b); chk("R10 one write clears", {15'h0, b[7]}, 16'h0000);

    // R11 pulse lasts one cycle
    setup(1'b0, 16'h0002);
    tick(2);
    chk("R11 before", {15'h0, ovf_pulse}, 16'h0000);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    chk("R11 pulse high", {15'h0, ovf_pulse}, 16'h0001);
    @(negedge clk);
    chk("R11 pulse gone", {15'h0, ovf_pulse}, 16'h0000);
    chk("R11 flag stays", {15'h0, ovf_flag}, 16'h0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule